// File: doc/BRIEF.md
# Selectable Audio Clock Ratio Generator

This block turns one fast timing clock into two families of audio clocks. The first family is a receive-side master clock, bit clock and frame clock. The second is a secondary bit clock and frame clock. Every output comes from one free-running divide counter, so all edges are phase-locked to each other. Register fields pick each output's ratio, and each output pin has its own invert bit.

There are two source modes. In synthesizer mode the source is 512fs. In crystal mode the source is a fixed 24.576 MHz or 12.288 MHz oscillator. The block's `clk` input runs at twice the source rate, so even the undivided master clock is a registered flop output. A frame period is `2^(FS_LOG2)` ticks in synthesizer mode. The counter spans `2^(FS_LOG2+2)` ticks, which is the longest frame period.

A bit clock is held off when its setting is too fast for the chosen master clock. In synthesizer mode it may not be faster than the master clock. In crystal mode it must be at most half the master clock. Settings are sampled only when the counter wraps, so no output ever shows a runt pulse. A one-cycle strobe per output marks every rising pin edge.

Top module: `audio_clk_ratio_gen`

## Requirements
- R1: While `rst` is high, all five pins and all strobes are low. From reset until the first counter wrap (the first 4096 ticks at the default `FS_LOG2=10`), the block runs the default setting and ignores the inputs. The default setting is synthesizer mode, master clock 512fs, secondary bit clock 64fs, secondary frame clock fs, and no inversion.
- R2: In synthesizer mode (`osc_mode`=0, one fs = 1024 ticks) the master clock period depends on `mclk_sel`. Codes 0, 1 and 2 give 512fs, 256fs and 128fs. Code 3 acts as 2. The receive bit clock is fixed at 64fs and the receive frame clock at fs. `rbck_sel` and `rlr_sel` are ignored.
- R3: In synthesizer mode `sbck_sel` codes 0..3 give 128fs, 64fs, 32fs and 16fs. `slr_sel` codes 0..3 give 2fs, fs, fs/2 and fs/4.
- R4: In crystal mode (`osc_mode`=1) `osc_fast`=1 selects a 24.576 MHz source and 0 selects 12.288 MHz. The tick rate is twice the source. `mclk_sel` codes 0, 1 and 2 divide the source by 1, 2 and 4. Code 3 acts as 2.
- R5: In crystal mode `rbck_sel` and `sbck_sel` codes 0, 1 and 2 give 12.288, 6.144 and 3.072 MHz. `rlr_sel` and `slr_sel` codes 0, 1 and 2 give 192, 96 and 48 kHz. Code 3 acts as 2 in all four fields.
- R6: `pol_inv` bit 0 inverts the master clock pin. Bit 1 inverts the receive bit clock, bit 2 the receive frame clock, bit 3 the secondary bit clock and bit 4 the secondary frame clock.
- R7: A bit clock is blocked in two cases: in synthesizer mode when it is faster than the master clock, and in crystal mode when it is faster than half the master clock. A blocked bit clock holds its pin at its invert bit and raises no strobe. Its frame clock keeps running.
- R8: At counter value 0 (tick 1 of each 4096-tick span after reset) the uninverted master and bit clocks are low and the frame clocks are high. Each output is a square wave from there. So every frame rising edge falls on a bit clock falling edge, and every bit clock edge falls on a master clock edge.
- R9: Inputs are sampled only on the tick where the counter wraps. A change in the middle of a span has no effect until the next span.
- R10: `edge_stb[i]` is high for exactly the tick in which pin i is high after being low. Bit order matches R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at twice the source rate |
| rst | input | 1 | Synchronous active-high reset |
| osc_mode | input | 1 | 0 synthesizer source, 1 crystal source |
| osc_fast | input | 1 | Crystal rate: 1 = 24.576 MHz, 0 = 12.288 MHz |
| mclk_sel | input | 2 | Master clock divide code |
| rbck_sel | input | 2 | Receive bit clock code (crystal mode) |
| rlr_sel | input | 2 | Receive frame clock code (crystal mode) |
| sbck_sel | input | 2 | Secondary bit clock code |
| slr_sel | input | 2 | Secondary frame clock code |
| pol_inv | input | 5 | Per-pin invert bits |
| mclk_o | output | 1 | Master clock |
| rbck_o | output | 1 | Receive bit clock |
| rlrck_o | output | 1 | Receive frame clock |
| sbck_o | output | 1 | Secondary bit clock |
| slrck_o | output | 1 | Secondary frame clock |
| edge_stb | output | 5 | One-tick rising-edge strobe per pin |

## Verification
The assertions check on every tick that the settings hold still between wraps, that the counter lands on zero after a wrap, and that a blocked bit clock sits at its invert level. They also check that each strobe marks a real low-to-high pin change, and that a frame rising edge never meets a high bit clock or master clock. Only the bench's scenarios can show the actual periods and phases of each ratio code in both modes and at both crystal rates. The same holds for the clamping of code 3, for the boundary cases of the blocking rule (equal rates, and exactly half), and for the default setting running until the first wrap.

// File: rtl/acg_pkg.sv
`timescale 1ns/1ps
package acg_pkg;
  localparam int N_OUT  = 5;
  localparam int O_MCLK = 0;
  localparam int O_RBCK = 1;
  localparam int O_RLR  = 2;
  localparam int O_SBCK = 3;
  localparam int O_SLR  = 4;

  // crystal mode: tick = 2x source, so 12.288 MHz from a 24.576 MHz crystal
  // is a period of 4 ticks (bit 1); 192 kHz is 256 ticks (bit 7)
  localparam int OSC_BCK_TAP = 1;
  localparam int OSC_LR_TAP  = 7;

  typedef struct packed {
    logic       osc_mode;
    logic       osc_fast;
    logic [1:0] mclk_sel;
    logic [1:0] rbck_sel;
    logic [1:0] rlr_sel;
    logic [1:0] sbck_sel;
    logic [1:0] slr_sel;
    logic [4:0] pol;
  } acg_cfg_t;

  localparam acg_cfg_t CFG_RESET = '{
    osc_mode: 1'b0, osc_fast: 1'b1, mclk_sel: 2'd0, rbck_sel: 2'd0,
    rlr_sel: 2'd0, sbck_sel: 2'd1, slr_sel: 2'd1, pol: 5'd0};

  // codes above 2 behave as 2
  function automatic int clamp2(input logic [1:0] s);
    return (s > 2'd2) ? 2 : int'(s);
  endfunction

  // counter bit that carries the master clock
  function automatic int mclk_tap(input acg_cfg_t c);
    return clamp2(c.mclk_sel);
  endfunction

  // counter bit for a bit clock; pll_tap is the synthesizer-mode choice
  function automatic int bck_tap(input acg_cfg_t c, input logic [1:0] sel,
                                 input int pll_tap);
    if (!c.osc_mode) return pll_tap;
    return OSC_BCK_TAP + clamp2(sel) - (c.osc_fast ? 0 : 1);
  endfunction

  // counter bit for a frame clock
  function automatic int lr_tap(input acg_cfg_t c, input logic [1:0] sel,
                                input int pll_tap);
    if (!c.osc_mode) return pll_tap;
    return OSC_LR_TAP + clamp2(sel) - (c.osc_fast ? 0 : 1);
  endfunction

  // lower tap = faster clock; crystal mode demands at least a factor two
  function automatic logic bck_blocked(input acg_cfg_t c, input int btap,
                                       input int mtap);
    return c.osc_mode ? (btap <= mtap) : (btap < mtap);
  endfunction
endpackage

// File: rtl/acg_div_counter.sv
`timescale 1ns/1ps
module acg_div_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // high on the tick whose edge takes the counter back to zero
  assign wrap = &cnt;

  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/acg_cfg_hold.sv
`timescale 1ns/1ps
module acg_cfg_hold
  import acg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wrap,
  input  acg_cfg_t cfg_in,
  output acg_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= CFG_RESET;
    else if (wrap) cfg_q <= cfg_in;
  end

  // R9
  cfg_still_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(cfg_q));
endmodule

// File: rtl/acg_tap_decode.sv
`timescale 1ns/1ps
module acg_tap_decode
  import acg_pkg::*;
#(
  parameter int FS_LOG2 = 10,
  parameter int TAP_W   = 4
) (
  input  acg_cfg_t                      cfg,
  output logic [N_OUT-1:0][TAP_W-1:0]   tap,
  output logic [N_OUT-1:0]              en
);
  // synthesizer mode: one fs spans 2^FS_LOG2 ticks
  localparam int PLL_RBCK_TAP  = FS_LOG2 - 7;  // 64fs
  localparam int PLL_RLR_TAP   = FS_LOG2 - 1;  // fs
  localparam int PLL_SBCK_TAP0 = FS_LOG2 - 8;  // 128fs at code 0
  localparam int PLL_SLR_TAP0  = FS_LOG2 - 2;  // 2fs at code 0

  int m_t, rb_t, sb_t;

  always_comb begin
    m_t  = mclk_tap(cfg);
    rb_t = bck_tap(cfg, cfg.rbck_sel, PLL_RBCK_TAP);
    sb_t = bck_tap(cfg, cfg.sbck_sel, PLL_SBCK_TAP0 + int'(cfg.sbck_sel));
    tap[O_MCLK] = TAP_W'(m_t);
    tap[O_RBCK] = TAP_W'(rb_t);
    tap[O_SBCK] = TAP_W'(sb_t);
    tap[O_RLR]  = TAP_W'(lr_tap(cfg, cfg.rlr_sel, PLL_RLR_TAP));
    tap[O_SLR]  = TAP_W'(lr_tap(cfg, cfg.slr_sel,
                                PLL_SLR_TAP0 + int'(cfg.slr_sel)));
    en          = '1;
    en[O_RBCK]  = !bck_blocked(cfg, rb_t, m_t);
    en[O_SBCK]  = !bck_blocked(cfg, sb_t, m_t);
  end
endmodule

// File: rtl/acg_pin_gen.sv
`timescale 1ns/1ps
module acg_pin_gen #(
  parameter int   CNT_W    = 12,
  parameter int   TAP_W    = 4,
  parameter logic IS_FRAME = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [TAP_W-1:0] tap,
  input  logic             en,
  input  logic             pol,
  output logic             pin,
  output logic             stb,
  output logic             lvl
);
  logic lvl_d, pin_d;

  // frame clocks are the inverted tap so they rise when the counter wraps
  always_comb begin
    lvl_d = en & (cnt[tap] ^ IS_FRAME);
    pin_d = lvl_d ^ pol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
      stb <= 1'b0;
      lvl <= 1'b0;
    end else begin
      pin <= pin_d;
      stb <= pin_d & ~pin;
      lvl <= lvl_d;
    end
  end

  // R10
  stb_rise_chk: assert property (@(posedge clk) disable iff (rst)
    stb |-> (pin && !$past(pin)));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pin == $past(pol)));
endmodule

// File: rtl/audio_clk_ratio_gen.sv
`timescale 1ns/1ps
module audio_clk_ratio_gen
  import acg_pkg::*;
#(
  parameter int FS_LOG2 = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_mode,
  input  logic       osc_fast,
  input  logic [1:0] mclk_sel,
  input  logic [1:0] rbck_sel,
  input  logic [1:0] rlr_sel,
  input  logic [1:0] sbck_sel,
  input  logic [1:0] slr_sel,
  input  logic [4:0] pol_inv,
  output logic       mclk_o,
  output logic       rbck_o,
  output logic       rlrck_o,
  output logic       sbck_o,
  output logic       slrck_o,
  output logic [4:0] edge_stb
);
  localparam int CNT_W = FS_LOG2 + 2;     // longest frame is fs/4
  localparam int TAP_W = $clog2(CNT_W);

  logic [CNT_W-1:0]            cnt;
  logic                        wrap;
  acg_cfg_t                    cfg_in, cfg_q;
  logic [N_OUT-1:0][TAP_W-1:0] tap;
  logic [N_OUT-1:0]            en;
  logic [N_OUT-1:0]            pin, stb, lvl;

  assign cfg_in = '{osc_mode: osc_mode, osc_fast: osc_fast,
                    mclk_sel: mclk_sel, rbck_sel: rbck_sel,
                    rlr_sel: rlr_sel, sbck_sel: sbck_sel,
                    slr_sel: slr_sel, pol: pol_inv};

  acg_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap));

  acg_cfg_hold u_cfg (
    .clk(clk), .rst(rst), .wrap(wrap), .cfg_in(cfg_in), .cfg_q(cfg_q));

  acg_tap_decode #(.FS_LOG2(FS_LOG2), .TAP_W(TAP_W)) u_dec (
    .cfg(cfg_q), .tap(tap), .en(en));

  for (genvar i = 0; i < N_OUT; i++) begin : g_pin
    acg_pin_gen #(
      .CNT_W(CNT_W), .TAP_W(TAP_W),
      .IS_FRAME((i == O_RLR) || (i == O_SLR))
    ) u_pin (
      .clk(clk), .rst(rst), .cnt(cnt), .tap(tap[i]), .en(en[i]),
      .pol(cfg_q.pol[i]), .pin(pin[i]), .stb(stb[i]), .lvl(lvl[i]));
  end

  assign mclk_o   = pin[O_MCLK];
  assign rbck_o   = pin[O_RBCK];
  assign rlrck_o  = pin[O_RLR];
  assign sbck_o   = pin[O_SBCK];
  assign slrck_o  = pin[O_SLR];
  assign edge_stb = stb;

  // R8
  rx_frame_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl[O_RLR]) |-> (!lvl[O_RBCK] && !lvl[O_MCLK]));

  // R8
  sec_frame_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl[O_SLR]) |-> (!lvl[O_SBCK] && !lvl[O_MCLK]));
endmodule

// File: tb/audio_clk_ratio_gen_test.sv
`timescale 1ns/1ps
module audio_clk_ratio_gen_test;
  localparam int SPAN = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_mode, osc_fast;
  logic [1:0] mclk_sel, rbck_sel, rlr_sel, sbck_sel, slr_sel;
  logic [4:0] pol_inv;
  logic       mclk_o, rbck_o, rlrck_o, sbck_o, slrck_o;
  logic [4:0] edge_stb;
  logic [4:0] pins;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;
  bit  prev_e [5];

  typedef struct {
    bit osc; bit fast; int ms; int rb; int rl; int sb; int sl; bit [4:0] pol;
  } bcfg_t;

  always #2.5 clk = ~clk;

  audio_clk_ratio_gen uut (
    .clk(clk), .rst(rst), .osc_mode(osc_mode), .osc_fast(osc_fast),
    .mclk_sel(mclk_sel), .rbck_sel(rbck_sel), .rlr_sel(rlr_sel),
    .sbck_sel(sbck_sel), .slr_sel(slr_sel), .pol_inv(pol_inv),
    .mclk_o(mclk_o), .rbck_o(rbck_o), .rlrck_o(rlrck_o),
    .sbck_o(sbck_o), .slrck_o(slrck_o), .edge_stb(edge_stb));

  assign pins = {slrck_o, sbck_o, rlrck_o, rbck_o, mclk_o};

  task automatic chk(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int cl(input int s);
    return (s > 2) ? 2 : s;
  endfunction

  // period in ticks, from the frequencies the requirements name
  function automatic int period(input bcfg_t c, input int o);
    int tick_khz, f;
    if (!c.osc) begin
      case (o)
        0:       return 1024 / (512 >> cl(c.ms));
        1:       return 1024 / 64;
        2:       return 1024;
        3:       return 1024 / (128 >> c.sb);
        default: return 512 << c.sl;
      endcase
    end
    tick_khz = c.fast ? 49152 : 24576;
    case (o)
      0:       f = (tick_khz / 2) >> cl(c.ms);
      1:       f = 12288 >> cl(c.rb);
      2:       f = 192 >> cl(c.rl);
      3:       f = 12288 >> cl(c.sb);
      default: f = 192 >> cl(c.sl);
    endcase
    return tick_khz / f;
  endfunction

  function automatic bit blocked(input bcfg_t c, input int o);
    int pb, pm;
    if (o != 1 && o != 3) return 0;
    pb = period(c, o);
    pm = period(c, 0);
    return c.osc ? (pb < 2 * pm) : (pb < pm);
  endfunction

  function automatic bit exp_lvl(input bcfg_t c, input int o, input int t);
    int p, ph;
    if (blocked(c, o)) return 0;
    p  = period(c, o);
    ph = t % p;
    return (o == 2 || o == 4) ? (ph < p / 2) : (ph >= p / 2);
  endfunction

  task automatic drive(input bcfg_t c);
    osc_mode = c.osc;
    osc_fast = c.fast;
    mclk_sel = 2'(c.ms);
    rbck_sel = 2'(c.rb);
    rlr_sel  = 2'(c.rl);
    sbck_sel = 2'(c.sb);
    slr_sel  = 2'(c.sl);
    pol_inv  = c.pol;
  endtask

  function automatic bcfg_t mk(input bit osc, input bit fast, input int ms,
      input int rb, input int rl, input int sb, input int sl,
      input bit [4:0] pol);
    bcfg_t c;
    c.osc = osc; c.fast = fast; c.ms = ms; c.rb = rb; c.rl = rl;
    c.sb = sb; c.sl = sl; c.pol = pol;
    return c;
  endfunction

  // one full counter span under setting cur, while nxt is already driven
  // (R9: nxt must not show before the wrap)
  task automatic run_span(input bcfg_t cur, input bcfg_t nxt,
                          input string tag);
    int  bad_p [5];
    int  bad_s [5];
    int  at_t  [5];
    bit  got_v [5];
    bit  exp_v [5];
    drive(nxt);
    for (int o = 0; o < 5; o++) begin
      bad_p[o] = 0; bad_s[o] = 0; at_t[o] = 0; got_v[o] = 0; exp_v[o] = 0;
    end
    for (int t = 0; t < SPAN; t++) begin
      @(negedge clk);
      for (int o = 0; o < 5; o++) begin
        bit e, es;
        e  = exp_lvl(cur, o, t) ^ cur.pol[o];
        es = e & ~prev_e[o];
        if (pins[o] !== e) begin
          if (bad_p[o] == 0) begin
            at_t[o] = t; got_v[o] = pins[o]; exp_v[o] = e;
          end
          bad_p[o]++;
        end
        if (edge_stb[o] !== es) bad_s[o]++;
        prev_e[o] = e;
      end
    end
    for (int o = 0; o < 5; o++) begin
      chk(bad_p[o] == 0, $sformatf(
        "%s pin%0d wave: got %b expected %b at tick %0d (%0d mismatches)",
        tag, o, got_v[o], exp_v[o], at_t[o], bad_p[o]));
      chk(bad_s[o] == 0, $sformatf(
        "R10 %s stb%0d: got %0d wrong ticks expected 0", tag, o, bad_s[o]));
    end
  endtask

  function automatic bcfg_t rnd_cfg();
    bcfg_t c;
    c.osc  = 1'($urandom_range(0, 1));
    c.fast = 1'($urandom_range(0, 1));
    c.ms   = $urandom_range(0, 3);
    c.rb   = $urandom_range(0, 3);
    c.rl   = $urandom_range(0, 3);
    c.sb   = $urandom_range(0, 3);
    c.sl   = $urandom_range(0, 3);
    c.pol  = 5'($urandom_range(0, 31));
    return c;
  endfunction

  initial begin
    bcfg_t dflt, cur, nxt;
    bcfg_t dir [7];
    void'($urandom(32'd20240611));
    dflt   = mk(0, 1, 0, 0, 0, 1, 1, 5'b00000);
    // R2 R3: synthesizer ratios
    dir[0] = mk(0, 0, 1, 3, 3, 0, 0, 5'b00000);
    // R3 R7: 128fs bit clock against 128fs master is allowed
    dir[1] = mk(0, 1, 2, 1, 2, 0, 3, 5'b00000);
    // R2 R6: code 3 clamp, every pin inverted
    dir[2] = mk(0, 0, 3, 0, 0, 3, 2, 5'b11111);
    // R4 R5 R7: fast crystal, 12.288 MHz bit clock under 24.576 MHz master
    dir[3] = mk(1, 1, 0, 0, 0, 2, 2, 5'b00000);
    // R7 R6: slow crystal, equal rate blocked, exactly half allowed
    dir[4] = mk(1, 0, 0, 0, 1, 1, 0, 5'b01010);
    // R5 R7: 6.144 MHz master blocks 6.144 MHz bit clock
    dir[5] = mk(1, 1, 2, 1, 3, 2, 1, 5'b10101);
    // R4 R5 R7: clamps in crystal mode, blocked secondary
    dir[6] = mk(1, 0, 3, 3, 1, 0, 0, 5'b01000);

    drive(dir[0]);
    repeat (4) @(negedge clk);
    chk(pins == 5'b0, $sformatf("R1 reset pins: got %b expected 00000", pins));
    chk(edge_stb == 5'b0,
        $sformatf("R1 reset strobes: got %b expected 00000", edge_stb));
    for (int o = 0; o < 5; o++) prev_e[o] = 0;
    rst = 1'b0;

    // first span runs defaults although dir[0] is on the inputs (R1, R9)
    cur = dflt;
    for (int k = 0; k < 7; k++) begin
      nxt = dir[k];
      run_span(cur, nxt, (k == 0) ? "R1 R8 R9 defaults" : "R2 R3 R4 R5 R6 R7 R8");
      cur = nxt;
    end
    for (int k = 0; k < 14; k++) begin
      nxt = rnd_cfg();
      run_span(cur, nxt, "R2 R3 R4 R5 R6 R7 R8 R9 random");
      cur = nxt;
    end
    run_span(cur, dflt, "R6 R7 R8 final");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got no completion expected end within 200000 ticks");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule